// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block sits between a dataflow execution fabric and a single memory port. The fabric fires load, store and memory-no-op requests whenever their operands arrive, so the requests reach the block in any order. Each request carries a wave number and a three-part ordering link: its own sequence number and, where the compiler could determine them, the sequence numbers of the memory operation before it and after it on the taken path. Either neighbour field may be a wildcard.

The sequencer parks requests in a small buffer and rebuilds program order from the links. After an operation has been issued, the block searches the buffer for the one request whose link proves it comes next. It never guesses across two wildcards. Loads and stores then go to a valid/ready memory port one at a time. No-ops only move the ordering point forward. Memory returns load data in issue order, and the block tags each returned word with the wave and sequence number of the load that asked for it. A wave is finished when its end-marked operation retires. The block then looks for sequence number 0 of the next wave.

Top module: `wave_order_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `req_ready` is 1, `mem_valid` is 0 and `ld_rsp_valid` is 0.
- R2: Whatever order requests arrive in, the loads and stores of a wave reach the memory port in ascending sequence-number order, and the first operation to retire in every wave is the one with sequence number 0.
- R3: When the last retired operation has a known successor (`req_succ_known` = 1), the buffered request of the current wave whose own sequence number equals that successor retires next.
- R4: When the last retired operation has a wildcard successor, the buffered request of the current wave whose predecessor is known and equals the last retired sequence number retires next.
- R5: A request with a wildcard predecessor never follows an operation with a wildcard successor. It stays buffered with no memory activity until a later retirement makes its link provable.
- R6: A request of kind 2 (no-op), and the unused kind 3, retires through the ordering check but never shows up on the memory port. Kind 0 is a load (`mem_we` = 0). Kind 1 is a store (`mem_we` = 1).
- R7: No request of wave w+1 reaches the memory port before the operation of wave w marked with `req_last` has retired. That retirement advances the expected wave by exactly one.
- R8: The buffer holds DEPTH requests. `req_ready` is 0 while all DEPTH entries are occupied, and a request is taken only when `req_valid` and `req_ready` are both 1.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, the request on the memory port stays valid and unchanged.
- R10: Each `mem_rsp_valid` pulse is passed to `ld_rsp_valid` in the same cycle with the returned data, and carries the wave and sequence number of the oldest load issued but not yet answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered by the fabric |
| req_ready | output | 1 | Buffer has a free entry |
| req_kind | input | 2 | 0 load, 1 store, 2 no-op, 3 treated as no-op |
| req_wave | input | WAVE_W | Wave number of the request |
| req_seq | input | SEQ_W | Own sequence number |
| req_pred | input | SEQ_W | Predecessor sequence number |
| req_pred_known | input | 1 | 0 marks the predecessor as wildcard |
| req_succ | input | SEQ_W | Successor sequence number |
| req_succ_known | input | 1 | 0 marks the successor as wildcard |
| req_last | input | 1 | Final operation of its wave |
| req_addr | input | ADDR_W | Memory address (loads, stores) |
| req_wdata | input | DATA_W | Store data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Store data |
| mem_rsp_valid | input | 1 | Load data returned, in issue order |
| mem_rsp_data | input | DATA_W | Returned load data |
| ld_rsp_valid | output | 1 | Tagged load result valid |
| ld_rsp_data | output | DATA_W | Load result |
| ld_rsp_wave | output | WAVE_W | Wave number of the answered load |
| ld_rsp_seq | output | SEQ_W | Sequence number of the answered load |

## Verification
The bench builds the block with its defaults: DEPTH 16, TAG_DEPTH 4, a 4-bit wave number and 6-bit sequence numbers. With these values a single 17-operation wave can fill every buffer entry plus the output register while the memory port is stalled, so the full condition is reachable. The bench sends waves in scrambled orders that cover known-successor links, wildcard-successor links, the double-wildcard hold that only a no-op releases, and a later wave waiting behind an unfinished one. Responses come back two cycles after each load is issued, and `mem_ready` is throttled throughout, so the tag queue runs with several loads outstanding.

// File: rtl/wo_pkg.sv
// Shared types for the wave-ordered request sequencer.
// Assumes: request kinds are carried as a 2-bit code on the fabric side.
package wo_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_NOP   = 2'd2,
        OP_RSVD  = 2'd3
    } op_kind_e;

    // Kinds that take part in ordering but never touch memory
    function automatic logic is_silent(input logic [1:0] k);
        return (k == OP_NOP) || (k == OP_RSVD);
    endfunction
endpackage

// File: rtl/wo_order_ctrl.sv
// Ordering state: expected wave and the link of the last retired operation.
// Assumes: at most one retirement per cycle; wave numbers wrap modulo 2**WAVE_W.
module wo_order_ctrl #(
    parameter int WAVE_W = 4,
    parameter int SEQ_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire,
    input  logic [SEQ_W-1:0]  ret_seq,
    input  logic [SEQ_W-1:0]  ret_succ,
    input  logic              ret_succ_known,
    input  logic              ret_last,
    output logic [WAVE_W-1:0] cur_wave,
    output logic              have_prev,
    output logic [SEQ_W-1:0]  prev_seq,
    output logic [SEQ_W-1:0]  prev_succ,
    output logic              prev_succ_known
);
    // Record the retired link, or open the next wave after its last operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wave        <= '0;
            have_prev       <= 1'b0;
            prev_seq        <= '0;
            prev_succ       <= '0;
            prev_succ_known <= 1'b0;
        end else if (retire) begin
            if (ret_last) begin
                cur_wave  <= cur_wave + 1'b1;
                have_prev <= 1'b0;
            end else begin
                have_prev <= 1'b1;
            end
            prev_seq        <= ret_seq;
            prev_succ       <= ret_succ;
            prev_succ_known <= ret_succ_known;
        end
    end
endmodule

// File: rtl/wo_req_buffer.sv
// Pending-request store with a per-entry link match against the ordering state.
// Assumes: links within a wave are unique, so at most one entry matches;
// the lowest index is taken if several do.
module wo_req_buffer #(
    parameter int DEPTH  = 16,
    parameter int WAVE_W = 4,
    parameter int SEQ_W  = 6,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [WAVE_W-1:0] wr_wave,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic [SEQ_W-1:0]  wr_pred,
    input  logic              wr_pred_known,
    input  logic [SEQ_W-1:0]  wr_succ,
    input  logic              wr_succ_known,
    input  logic              wr_last,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic [WAVE_W-1:0] cur_wave,
    input  logic              have_prev,
    input  logic [SEQ_W-1:0]  prev_seq,
    input  logic [SEQ_W-1:0]  prev_succ,
    input  logic              prev_succ_known,
    output logic              full,
    output logic              hit,
    output logic [1:0]        hit_kind,
    output logic [SEQ_W-1:0]  hit_seq,
    output logic [SEQ_W-1:0]  hit_succ,
    output logic              hit_succ_known,
    output logic              hit_last,
    output logic [ADDR_W-1:0] hit_addr,
    output logic [DATA_W-1:0] hit_data,
    output logic [WAVE_W-1:0] hit_wave
);
    logic [DEPTH-1:0]  vld;
    logic [DEPTH-1:0]  match;
    logic [1:0]        e_kind [DEPTH];
    logic [WAVE_W-1:0] e_wave [DEPTH];
    logic [SEQ_W-1:0]  e_seq  [DEPTH];
    logic [SEQ_W-1:0]  e_pred [DEPTH];
    logic              e_pk   [DEPTH];
    logic [SEQ_W-1:0]  e_succ [DEPTH];
    logic              e_sk   [DEPTH];
    logic              e_last [DEPTH];
    logic [ADDR_W-1:0] e_addr [DEPTH];
    logic [DATA_W-1:0] e_data [DEPTH];
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  hit_idx;

    assign full = &vld;
    assign hit  = |match;

    // One link comparator per entry
    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        logic follows;
        always_comb begin
            if (!have_prev)
                follows = (e_seq[i] == '0);
            else if (prev_succ_known)
                follows = (e_seq[i] == prev_succ);
            else
                follows = e_pk[i] && (e_pred[i] == prev_seq);
            match[i] = vld[i] && (e_wave[i] == cur_wave) && follows;
        end
    end

    // Lowest free slot for the next write
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!vld[i]) free_idx = IDX_W'(i);
    end

    // Lowest matching slot for the next retirement
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (match[i]) hit_idx = IDX_W'(i);
    end

    assign hit_kind       = e_kind[hit_idx];
    assign hit_wave       = e_wave[hit_idx];
    assign hit_seq        = e_seq[hit_idx];
    assign hit_succ       = e_succ[hit_idx];
    assign hit_succ_known = e_sk[hit_idx];
    assign hit_last       = e_last[hit_idx];
    assign hit_addr       = e_addr[hit_idx];
    assign hit_data       = e_data[hit_idx];

    // Occupancy: set on write, clear on retirement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (take && hit) vld[hit_idx] <= 1'b0;
            if (wr_en && !full) vld[free_idx] <= 1'b1;
        end
    end

    // Entry payload capture
    always_ff @(posedge clk) begin
        if (wr_en && !full) begin
            e_kind[free_idx] <= wr_kind;
            e_wave[free_idx] <= wr_wave;
            e_seq[free_idx]  <= wr_seq;
            e_pred[free_idx] <= wr_pred;
            e_pk[free_idx]   <= wr_pred_known;
            e_succ[free_idx] <= wr_succ;
            e_sk[free_idx]   <= wr_succ_known;
            e_last[free_idx] <= wr_last;
            e_addr[free_idx] <= wr_addr;
            e_data[free_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/wo_tag_fifo.sv
// In-order queue of wave/sequence tags for loads awaiting data.
// Assumes: DEPTH is a power of two; pop is never asked of an empty queue.
module wo_tag_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 10,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic [PW:0]  count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;

    assign full = (count == (PW+1)'(DEPTH));
    assign dout = mem[rp];

    // Pointer and fill-level upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            count <= count + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // Tag storage write
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end
endmodule

// File: rtl/wave_order_seq.sv
// Top: buffers out-of-order memory requests and issues them in wave order.
// Assumes: the memory answers loads in issue order; responses cannot be stalled.
module wave_order_seq #(
    parameter int DEPTH     = 16,
    parameter int TAG_DEPTH = 4,
    parameter int WAVE_W    = 4,
    parameter int SEQ_W     = 6,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [WAVE_W-1:0] req_wave,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [SEQ_W-1:0]  req_pred,
    input  logic              req_pred_known,
    input  logic [SEQ_W-1:0]  req_succ,
    input  logic              req_succ_known,
    input  logic              req_last,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              ld_rsp_valid,
    output logic [DATA_W-1:0] ld_rsp_data,
    output logic [WAVE_W-1:0] ld_rsp_wave,
    output logic [SEQ_W-1:0]  ld_rsp_seq
);
    import wo_pkg::*;

    localparam int TAG_W  = WAVE_W + SEQ_W;
    localparam int TCNT_W = ((TAG_DEPTH > 1) ? $clog2(TAG_DEPTH) : 1) + 1;

    logic              buf_full, hit, hit_succ_known, hit_last;
    logic [1:0]        hit_kind;
    logic [WAVE_W-1:0] hit_wave;
    logic [SEQ_W-1:0]  hit_seq, hit_succ;
    logic [ADDR_W-1:0] hit_addr;
    logic [DATA_W-1:0] hit_data;
    logic [WAVE_W-1:0] cur_wave;
    logic              have_prev, prev_succ_known;
    logic [SEQ_W-1:0]  prev_seq, prev_succ;

    logic              out_valid;
    logic [1:0]        out_kind;
    logic [WAVE_W-1:0] out_wave;
    logic [SEQ_W-1:0]  out_seq;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;

    logic              tag_full;
    logic [TCNT_W-1:0] tag_count;
    logic [TAG_W-1:0]  tag_out;
    logic              mem_fire, out_free, retire, load_out, silent_hit;

    assign req_ready  = !buf_full;
    assign silent_hit = hit && is_silent(hit_kind);
    assign mem_valid  = out_valid && !((out_kind == OP_LOAD) && tag_full);
    assign mem_fire   = mem_valid && mem_ready;
    assign out_free   = !out_valid || mem_fire;
    assign load_out   = hit && !silent_hit && out_free;
    assign retire     = silent_hit || load_out;

    assign mem_we    = (out_kind == OP_STORE);
    assign mem_addr  = out_addr;
    assign mem_wdata = out_data;

    assign ld_rsp_valid = mem_rsp_valid;
    assign ld_rsp_data  = mem_rsp_data;
    assign ld_rsp_wave  = tag_out[TAG_W-1:SEQ_W];
    assign ld_rsp_seq   = tag_out[SEQ_W-1:0];

    wo_req_buffer #(
        .DEPTH(DEPTH), .WAVE_W(WAVE_W), .SEQ_W(SEQ_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) buf_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_valid), .wr_kind(req_kind), .wr_wave(req_wave),
        .wr_seq(req_seq), .wr_pred(req_pred), .wr_pred_known(req_pred_known),
        .wr_succ(req_succ), .wr_succ_known(req_succ_known), .wr_last(req_last),
        .wr_addr(req_addr), .wr_data(req_wdata),
        .take(retire),
        .cur_wave(cur_wave), .have_prev(have_prev), .prev_seq(prev_seq),
        .prev_succ(prev_succ), .prev_succ_known(prev_succ_known),
        .full(buf_full), .hit(hit), .hit_kind(hit_kind), .hit_seq(hit_seq),
        .hit_succ(hit_succ), .hit_succ_known(hit_succ_known), .hit_last(hit_last),
        .hit_addr(hit_addr), .hit_data(hit_data), .hit_wave(hit_wave)
    );

    wo_order_ctrl #(.WAVE_W(WAVE_W), .SEQ_W(SEQ_W)) ord_i (
        .clk(clk), .rst_n(rst_n),
        .retire(retire), .ret_seq(hit_seq), .ret_succ(hit_succ),
        .ret_succ_known(hit_succ_known), .ret_last(hit_last),
        .cur_wave(cur_wave), .have_prev(have_prev), .prev_seq(prev_seq),
        .prev_succ(prev_succ), .prev_succ_known(prev_succ_known)
    );

    wo_tag_fifo #(.DEPTH(TAG_DEPTH), .W(TAG_W)) tag_i (
        .clk(clk), .rst_n(rst_n),
        .push(mem_fire && (out_kind == OP_LOAD)),
        .din({out_wave, out_seq}),
        .pop(mem_rsp_valid),
        .dout(tag_out), .full(tag_full), .count(tag_count)
    );

    // Output register: holds the issued request until the memory accepts it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= OP_NOP;
            out_wave  <= '0;
            out_seq   <= '0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (load_out) begin
            out_valid <= 1'b1;
            out_kind  <= hit_kind;
            out_wave  <= hit_wave;
            out_seq   <= hit_seq;
            out_addr  <= hit_addr;
            out_data  <= hit_data;
        end else if (mem_fire) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/wo_seq_chk.sv
// Property checker for wave_order_seq, attached with bind below.
// Assumes: the memory side returns no data for an unasked load.
module wo_seq_chk #(
    parameter int WAVE_W = 4,
    parameter int SEQ_W  = 6,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [1:0]        out_kind,
    input logic [WAVE_W-1:0] out_wave,
    input logic [SEQ_W-1:0]  out_seq,
    input logic              ld_rsp_valid,
    input logic [CNT_W-1:0]  tag_count
);
    logic              seen;
    logic [WAVE_W-1:0] last_wave;
    logic [SEQ_W-1:0]  last_seq;
    logic              fire;

    assign fire = mem_valid && mem_ready;

    // Remember the most recent issued operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            last_wave <= '0;
            last_seq  <= '0;
        end else if (fire) begin
            seen      <= 1'b1;
            last_wave <= out_wave;
            last_seq  <= out_seq;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!mem_valid && req_ready));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6
    silent_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (out_kind == 2'd0 || out_kind == 2'd1));

    // R2
    seq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && seen && out_wave == last_wave) |-> (out_seq > last_seq));

    // R7
    wave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && seen) |-> (out_wave == last_wave || out_wave == WAVE_W'(last_wave + 1'b1)));

    // R10
    rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_rsp_valid |-> (tag_count != '0));
endmodule

bind wave_order_seq wo_seq_chk #(
    .WAVE_W(WAVE_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(TCNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .out_kind(out_kind), .out_wave(out_wave), .out_seq(out_seq),
    .ld_rsp_valid(ld_rsp_valid), .tag_count(tag_count)
);

// File: tb/wave_order_seq_tb_top.sv
// Bench: scrambled waves in, issue order and tagged load data checked against a
// behavioural model built from queues.
module wave_order_seq_tb_top;
    localparam int WAVE_W = 4;
    localparam int SEQ_W  = 6;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef struct {
        int          kind;
        int          wave;
        int          seq;
        int          pred;
        bit          pk;
        int          succ;
        bit          sk;
        bit          last;
        logic [15:0] addr;
        logic [31:0] data;
    } op_t;

    typedef struct {
        int          wave;
        int          seq;
        logic [31:0] data;
    } rsp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [WAVE_W-1:0] req_wave = '0;
    logic [SEQ_W-1:0]  req_seq = '0, req_pred = '0, req_succ = '0;
    logic              req_pred_known = 1'b0, req_succ_known = 1'b0, req_last = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              mem_valid, mem_we;
    logic              mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              ld_rsp_valid;
    logic [DATA_W-1:0] ld_rsp_data;
    logic [WAVE_W-1:0] ld_rsp_wave;
    logic [SEQ_W-1:0]  ld_rsp_seq;

    wave_order_seq dut_i (.*);

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   hold = 1'b0;
    op_t  exp_q[$];
    rsp_t rsp_q[$];
    op_t  pend[$];
    logic [31:0] ram [256];
    logic [31:0] ref_ram [256];
    logic        p1_v = 1'b0;
    logic [31:0] p1_d = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i]     = 32'hA500_0000 + i;
            ref_ram[i] = 32'hA500_0000 + i;
        end
    end

    // Memory model: throttled ready, writes, loads answered two cycles later
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= !hold && ((cyc % 5) != 3);
        if (mem_valid && mem_ready && mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        p1_v <= mem_valid && mem_ready && !mem_we;
        p1_d <= ram[mem_addr[7:0]];
        mem_rsp_valid <= p1_v;
        mem_rsp_data  <= p1_d;
    end

    // Per-clock comparison of memory port and response channel with the model
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2/R6 unexpected issue addr=%h expected none", mem_addr);
            end else begin
                op_t e;
                e = exp_q.pop_front();
                if (mem_we !== (e.kind == 1) || mem_addr !== e.addr ||
                    (e.kind == 1 && mem_wdata !== e.data)) begin
                    failures++;
                    $display("FAIL R2/R3/R4 issue we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h (wave %0d seq %0d)",
                             mem_we, mem_addr, mem_wdata, e.kind == 1, e.addr, e.data, e.wave, e.seq);
                end
                if (e.kind == 1) ref_ram[e.addr[7:0]] = e.data;
                else rsp_q.push_back('{wave: e.wave, seq: e.seq, data: ref_ram[e.addr[7:0]]});
            end
        end
        if (rst_n && ld_rsp_valid) begin
            checks++;
            if (rsp_q.size() == 0) begin
                failures++;
                $display("FAIL R10 unexpected response data=%h expected none", ld_rsp_data);
            end else begin
                rsp_t r;
                r = rsp_q.pop_front();
                if (ld_rsp_data !== r.data || ld_rsp_wave !== WAVE_W'(r.wave) || ld_rsp_seq !== SEQ_W'(r.seq)) begin
                    failures++;
                    $display("FAIL R10 response wave=%0d seq=%0d data=%h expected wave=%0d seq=%0d data=%h",
                             ld_rsp_wave, ld_rsp_seq, ld_rsp_data, r.wave, r.seq, r.data);
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic add(input int kind, input int wave, input int seq, input int pred, input bit pk,
                       input int succ, input bit sk, input bit last, input logic [15:0] addr,
                       input logic [31:0] data);
        op_t o;
        o = '{kind: kind, wave: wave, seq: seq, pred: pred, pk: pk, succ: succ, sk: sk,
              last: last, addr: addr, data: data};
        pend.push_back(o);
        if (kind == 0 || kind == 1) exp_q.push_back(o);
    endtask

    task automatic send(input int idx);
        op_t o;
        o = pend[idx];
        @(negedge clk);
        req_valid      = 1'b1;
        req_kind       = 2'(o.kind);
        req_wave       = WAVE_W'(o.wave);
        req_seq        = SEQ_W'(o.seq);
        req_pred       = SEQ_W'(o.pred);
        req_pred_known = o.pk;
        req_succ       = SEQ_W'(o.succ);
        req_succ_known = o.sk;
        req_last       = o.last;
        req_addr       = o.addr;
        req_wdata      = o.data;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1, "R1 req_ready in reset", req_ready, 1);
        check(mem_valid === 1'b0, "R1 mem_valid in reset", mem_valid, 0);
        check(ld_rsp_valid === 1'b0, "R1 ld_rsp_valid in reset", ld_rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_valid === 1'b0 && req_ready === 1'b1, "R1 first cycle after reset", mem_valid, 0);

        // Wave 0: straight line with known links, arriving reversed (R2, R3)
        add(1, 0, 0, 0, 0, 1, 1, 0, 16'h0010, 32'h1111_0000);
        add(0, 0, 1, 0, 1, 2, 1, 0, 16'h0010, 0);
        add(1, 0, 2, 1, 1, 3, 1, 0, 16'h0011, 32'h2222_0000);
        add(0, 0, 3, 2, 1, 0, 0, 1, 16'h0011, 0);
        send(3); send(1); send(2); send(0);
        pend.delete();
        drain();

        // Wave 1: wildcard successors resolved by known predecessors (R4)
        add(1, 1, 0, 0, 0, 0, 0, 0, 16'h0020, 32'h3333_0000);
        add(0, 1, 2, 0, 1, 3, 1, 0, 16'h0020, 0);
        add(1, 1, 3, 2, 1, 0, 0, 0, 16'h0021, 32'h4444_0000);
        add(0, 1, 5, 3, 1, 0, 0, 1, 16'h0021, 0);
        send(3); send(2); send(1); send(0);
        pend.delete();
        drain();

        // Wave 2 double wildcard held until a no-op resolves it; wave 3 waits (R5, R6, R7)
        add(1, 2, 0, 0, 0, 0, 0, 0, 16'h0030, 32'h5555_0000);
        add(0, 2, 2, 0, 0, 3, 1, 0, 16'h0030, 0);
        add(1, 2, 3, 2, 1, 0, 0, 1, 16'h0031, 32'h6666_0000);
        add(2, 2, 1, 0, 1, 2, 1, 0, 16'h00EE, 32'hDEAD_BEEF);
        add(0, 3, 0, 0, 0, 1, 1, 0, 16'h0031, 0);
        add(1, 3, 1, 0, 1, 0, 0, 1, 16'h0040, 32'h7777_0000);
        send(0); send(1); send(2); send(4); send(5);
        repeat (20) @(negedge clk);
        // R5: only wave 2 seq 0 may have issued; R7: wave 3 seq 0 not issued
        check(exp_q.size() == 4, "R5/R7 pending ops while link ambiguous", exp_q.size(), 4);
        check(mem_valid === 1'b0, "R5 memory idle while ambiguous", mem_valid, 0);
        send(3);
        pend.delete();
        drain();
        // R6: no-op address never written
        check(ram[8'hEE] === 32'hA500_00EE, "R6 no-op left memory untouched", ram[8'hEE], 32'hA500_00EE);

        // Wave 4: fill the buffer with memory stalled (R8, R9)
        hold = 1'b1;
        for (int i = 0; i <= 16; i++)
            add(1, 4, i, i - 1, i > 0, i + 1, i < 16, i == 16, 16'(16'h0050 + i), 32'hC000_0000 + i);
        send(0);
        for (int i = 16; i >= 1; i--) send(i);
        repeat (3) @(negedge clk);
        check(req_ready === 1'b0, "R8 req_ready low with buffer full", req_ready, 0);
        check(mem_valid === 1'b1 && mem_addr === 16'h0050, "R9 stalled request held", mem_addr, 16'h0050);
        repeat (5) @(negedge clk);
        check(mem_valid === 1'b1 && mem_addr === 16'h0050, "R9 stalled request still held", mem_addr, 16'h0050);
        hold = 1'b0;
        pend.delete();
        drain();
        check(req_ready === 1'b1, "R8 req_ready back after drain", req_ready, 1);

        // Final: everything expected was issued and answered (R2, R10)
        check(exp_q.size() == 0, "R2 all expected ops issued", exp_q.size(), 0);
        check(rsp_q.size() == 0, "R10 all load responses seen", rsp_q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule